// File: doc/BRIEF.md
# Flash Write-Completion Status Poller

This block sits on the host side of a parallel byte-wide flash interface. A command sequencer issues a program or erase sequence and pulses `start_i` at its beginning, along with the operation kind, the detection mode and the byte being written. The poller counts the write strobes of that sequence. Once the sequence has gone far enough for the status bits to mean anything, it reads the device over and over through a simple request/valid read port until the status shows that the internal write has finished.

Two detection modes are available. In data-poll mode, bit 7 of each read is compared against a rule that depends on the operation. In toggle mode, bit 6 of each read is compared with bit 6 of the previous read. A read can land at the same moment the device finishes, so an apparent completion is never trusted at once. The poller first waits a settling interval, then reads the location two more times. It reports success only when both of those reads are valid. A busy status during confirmation sends it back to polling. A settled status carrying wrong data is reported as a failure. If the device keeps showing busy for too many polls, a timeout is reported instead.

Top module: `flash_wstat_poller`

## Requirements
- R1: While idle, a `start_i` pulse raises `busy_o` on the next cycle and latches mode (`mode_i`: 0 = data-poll, 1 = toggle), operation (`op_i`: 0 = program, 1 = erase) and expected byte. While `busy_o` is high, `start_i` and those inputs are ignored.
- R2: No read is requested until `wr_strobe_i` has been seen high on PROG_STROBES (default 4) cycles for a program, or ERASE_STROBES (default 6) cycles for an erase, counted from the cycle after the start. The first request appears in the cycle after the last counted strobe.
- R3: In data-poll mode for a program, a read whose bit 7 differs from bit 7 of the expected byte means busy. A read whose bit 7 equals it is an apparent completion.
- R4: In data-poll mode for an erase, bit 7 = 0 means busy and bit 7 = 1 is an apparent completion.
- R5: In toggle mode, a read is an apparent completion only when its bit 6 equals bit 6 of the immediately preceding read of the same operation. The first read of an operation is never a completion.
- R6: After an apparent completion, `rd_req_o` stays low for exactly SETTLE_CYC cycles. Exactly two confirmation reads then follow.
- R7: `done_o` pulses only when both confirmation reads show a completed status and return the exact target byte. The target byte is the expected byte for a program and 8'hFF for an erase.
- R8: A confirmation read that shows busy status returns the poller to polling without a result. A later completion goes through the full settle-and-confirm step again.
- R9: A confirmation read with completed status but a byte different from the target ends the operation with an `err_o` pulse.
- R10: After MAX_POLLS polling reads that all show busy, the operation ends with a `tmo_o` pulse. A completion on polling read number MAX_POLLS still succeeds.
- R11: `done_o`, `err_o` and `tmo_o` are one-cycle pulses. At most one of them is high at a time, and it is high in the first cycle in which `busy_o` is low again.
- R12: While reset is held and after it, `busy_o`, `rd_req_o`, `done_o`, `err_o` and `tmo_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin tracking one program or erase operation |
| mode_i | input | 1 | Detection mode: 0 data-poll on bit 7, 1 toggle on bit 6 |
| op_i | input | 1 | Operation kind: 0 program, 1 sector/chip erase |
| exp_data_i | input | 8 | Byte being programmed |
| wr_strobe_i | input | 1 | One cycle per write strobe of the command sequence |
| rd_req_o | output | 1 | Read request; held until a cycle with `rd_valid_i` |
| rd_valid_i | input | 1 | Read data valid; completes the request in this cycle |
| rd_data_i | input | 8 | Byte read from the device |
| busy_o | output | 1 | Operation being tracked |
| done_o | output | 1 | Pulse: completion confirmed |
| err_o | output | 1 | Pulse: settled data did not match target |
| tmo_o | output | 1 | Pulse: poll limit reached while still busy |

## Verification
Some properties are checked on every cycle by the assertions. These are the pulse shape and exclusivity of the result flags and their alignment with the fall of `busy_o`. They also cover the bounds of the strobe, settle and poll counters, the strobe that must come just before the first read, and the way the latched job stays stable while busy. Other behaviour only shows up in the directed scenarios, because it depends on a whole sequence of device responses. This includes the data-poll rules for program and erase, the toggle comparison and its first-read exception, and the number of reads and length of the quiet gap before confirmation. It also includes the return to polling after a busy confirmation read, the mismatch failure, the timeout boundary and the rejection of a second start.

// File: rtl/fwp_pkg.sv
package fwp_pkg;

    localparam int          STATUS_BIT  = 7;
    localparam int          TOGGLE_BIT  = 6;
    localparam logic [7:0]  ERASED_BYTE = 8'hFF;

    typedef enum logic {
        MODE_DATA   = 1'b0,
        MODE_TOGGLE = 1'b1
    } poll_mode_e;

    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } op_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ARM,
        PH_POLL,
        PH_SETTLE,
        PH_CONF
    } phase_e;

    typedef struct packed {
        poll_mode_e mode;
        op_kind_e   op;
        logic [7:0] expect_byte;
    } job_t;

    typedef struct packed {
        logic vld;
        logic bit6;
    } toggle_hist_t;

    typedef struct packed {
        logic settled;
        logic byte_ok;
    } verdict_t;

    typedef struct packed {
        logic done;
        logic fail;
        logic timeout;
    } result_t;

    function automatic logic [7:0] target_byte(job_t j);
        return (j.op == OP_ERASE) ? ERASED_BYTE : j.expect_byte;
    endfunction

    function automatic logic data_poll_settled(job_t j, logic b7);
        if (j.op == OP_ERASE)
            return b7;
        return b7 == j.expect_byte[STATUS_BIT];
    endfunction

endpackage

// File: rtl/fwp_limit_cnt.sv
module fwp_limit_cnt #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [W-1:0] cnt_q;

    assign last_o = inc_i && (cnt_q == W'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clr_i)
            cnt_q <= '0;
        else if (inc_i)
            cnt_q <= last_o ? '0 : cnt_q + W'(1);
    end

    // R6 R10
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) < LIMIT);

endmodule

// File: rtl/fwp_strobe_gate.sv
module fwp_strobe_gate
    import fwp_pkg::*;
#(
    parameter int PROG_STROBES  = 4,
    parameter int ERASE_STROBES = 6
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clr_i,
    input  logic     active_i,
    input  op_kind_e op_i,
    input  logic     wstb_i,
    output logic     ready_o
);
    localparam int TOP = (PROG_STROBES > ERASE_STROBES) ? PROG_STROBES : ERASE_STROBES;
    localparam int CW  = $clog2(TOP + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] need;

    assign need    = (op_i == OP_ERASE) ? CW'(ERASE_STROBES) : CW'(PROG_STROBES);
    assign ready_o = active_i && wstb_i && ((cnt_q + CW'(1)) == need);

    always_ff @(posedge clk) begin
        if (rst || clr_i)
            cnt_q <= '0;
        else if (active_i && wstb_i)
            cnt_q <= ready_o ? '0 : cnt_q + CW'(1);
    end

    // R2
    strobe_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q < need);

endmodule

// File: rtl/fwp_status_eval.sv
module fwp_status_eval
    import fwp_pkg::*;
(
    input  job_t         job_i,
    input  toggle_hist_t hist_i,
    input  logic [7:0]   rd_data_i,
    output verdict_t     verdict_o
);
    always_comb begin
        verdict_o = '0;
        unique case (job_i.mode)
            MODE_DATA:
                verdict_o.settled = data_poll_settled(job_i, rd_data_i[STATUS_BIT]);
            MODE_TOGGLE:
                verdict_o.settled = hist_i.vld && (rd_data_i[TOGGLE_BIT] == hist_i.bit6);
            default:
                verdict_o.settled = 1'b0;
        endcase
        verdict_o.byte_ok = (rd_data_i == target_byte(job_i));
    end

endmodule

// File: rtl/flash_wstat_poller.sv
module flash_wstat_poller
    import fwp_pkg::*;
#(
    parameter int PROG_STROBES  = 4,
    parameter int ERASE_STROBES = 6,
    parameter int SETTLE_CYC    = 125,
    parameter int MAX_POLLS     = 1000,
    parameter int CONFIRM_READS = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       mode_i,
    input  logic       op_i,
    input  logic [7:0] exp_data_i,
    input  logic       wr_strobe_i,
    output logic       rd_req_o,
    input  logic       rd_valid_i,
    input  logic [7:0] rd_data_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       err_o,
    output logic       tmo_o
);
    localparam int CIW = (CONFIRM_READS > 1) ? $clog2(CONFIRM_READS) : 1;

    phase_e       phase_q;
    job_t         job_q;
    job_t         job_in;
    toggle_hist_t hist_q;
    toggle_hist_t hist_nx;
    result_t      res_q;
    logic [CIW-1:0] conf_q;
    verdict_t     verdict;

    logic accept;
    logic xfer;
    logic gate_ready;
    logic enter_settle;
    logic settle_last;
    logic poll_busy;
    logic poll_last;

    assign job_in = '{mode: poll_mode_e'(mode_i), op: op_kind_e'(op_i), expect_byte: exp_data_i};

    assign busy_o   = (phase_q != PH_IDLE);
    assign rd_req_o = (phase_q == PH_POLL) || (phase_q == PH_CONF);
    assign xfer     = rd_req_o && rd_valid_i;
    assign accept   = (phase_q == PH_IDLE) && start_i;

    assign enter_settle = (phase_q == PH_POLL) && xfer && verdict.settled;
    assign poll_busy    = (phase_q == PH_POLL) && xfer && !verdict.settled;
    assign hist_nx      = '{vld: 1'b1, bit6: rd_data_i[TOGGLE_BIT]};

    assign done_o = res_q.done;
    assign err_o  = res_q.fail;
    assign tmo_o  = res_q.timeout;

    fwp_strobe_gate #(
        .PROG_STROBES  (PROG_STROBES),
        .ERASE_STROBES (ERASE_STROBES)
    ) u_gate (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (accept),
        .active_i (phase_q == PH_ARM),
        .op_i     (job_q.op),
        .wstb_i   (wr_strobe_i),
        .ready_o  (gate_ready)
    );

    fwp_status_eval u_eval (
        .job_i     (job_q),
        .hist_i    (hist_q),
        .rd_data_i (rd_data_i),
        .verdict_o (verdict)
    );

    fwp_limit_cnt #(.LIMIT(SETTLE_CYC)) u_settle (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (accept || enter_settle),
        .inc_i  (phase_q == PH_SETTLE),
        .last_o (settle_last)
    );

    fwp_limit_cnt #(.LIMIT(MAX_POLLS)) u_polls (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (accept),
        .inc_i  (poll_busy),
        .last_o (poll_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            job_q   <= '0;
            hist_q  <= '0;
            conf_q  <= '0;
            res_q   <= '0;
        end else begin
            res_q <= '0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        job_q   <= job_in;
                        hist_q  <= '0;
                        phase_q <= PH_ARM;
                    end
                end
                PH_ARM: begin
                    if (gate_ready)
                        phase_q <= PH_POLL;
                end
                PH_POLL: begin
                    if (xfer) begin
                        hist_q <= hist_nx;
                        if (verdict.settled) begin
                            conf_q  <= '0;
                            phase_q <= PH_SETTLE;
                        end else if (poll_last) begin
                            res_q.timeout <= 1'b1;
                            phase_q       <= PH_IDLE;
                        end
                    end
                end
                PH_SETTLE: begin
                    if (settle_last)
                        phase_q <= PH_CONF;
                end
                PH_CONF: begin
                    if (xfer) begin
                        hist_q <= hist_nx;
                        if (!verdict.settled) begin
                            phase_q <= PH_POLL;
                        end else if (!verdict.byte_ok) begin
                            res_q.fail <= 1'b1;
                            phase_q    <= PH_IDLE;
                        end else if (conf_q == CIW'(CONFIRM_READS - 1)) begin
                            res_q.done <= 1'b1;
                            phase_q    <= PH_IDLE;
                        end else begin
                            conf_q <= conf_q + CIW'(1);
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // R12
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!busy_o && !rd_req_o && !done_o && !err_o && !tmo_o));

    // R1
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    // R1
    job_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> $stable(job_q));

    // R2
    first_read_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_POLL && $past(phase_q) == PH_ARM) |-> $past(wr_strobe_i));

    // R6
    settle_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_CONF && $past(phase_q) == PH_SETTLE) |-> $past(settle_last));

    // R7
    done_source_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(phase_q) == PH_CONF && $past(rd_valid_i)));

    // R10
    timeout_source_chk: assert property (@(posedge clk) disable iff (rst)
        tmo_o |-> ($past(phase_q) == PH_POLL && $past(rd_valid_i)));

    // R11
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done_o, err_o, tmo_o}));

    // R11
    flag_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o || err_o || tmo_o) |=> !(done_o || err_o || tmo_o));

    // R11
    flag_busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o || err_o || tmo_o) |-> (!busy_o && $past(busy_o)));

endmodule

// File: tb/flash_wstat_poller_tb.sv
module flash_wstat_poller_tb;

    localparam int PSTB   = 4;
    localparam int ESTB   = 6;
    localparam int SETTLE = 8;
    localparam int MAXP   = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       mode = 1'b0;
    logic       op = 1'b0;
    logic [7:0] exp_b = 8'h00;
    logic       wstb = 1'b0;
    logic       rd_req;
    logic       rd_valid = 1'b0;
    logic [7:0] rd_data = 8'h00;
    logic       busy, done, err, tmo;

    int errs = 0;
    int checks = 0;
    int cycles = 0;

    // device model configuration
    logic       m_mode = 1'b0;
    logic       m_op = 1'b0;
    logic [7:0] m_exp = 8'h00;
    logic [7:0] m_fin = 8'h00;
    int         m_busy_n = 0;
    int         m_glitch = -1;
    int         k = 0;
    int         run = 0;
    int         ngaps = 0;
    int         lastgap = 0;

    always #4 clk = ~clk;

    flash_wstat_poller #(
        .PROG_STROBES  (PSTB),
        .ERASE_STROBES (ESTB),
        .SETTLE_CYC    (SETTLE),
        .MAX_POLLS     (MAXP),
        .CONFIRM_READS (2)
    ) u_dut (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .mode_i      (mode),
        .op_i        (op),
        .exp_data_i  (exp_b),
        .wr_strobe_i (wstb),
        .rd_req_o    (rd_req),
        .rd_valid_i  (rd_valid),
        .rd_data_i   (rd_data),
        .busy_o      (busy),
        .done_o      (done),
        .err_o       (err),
        .tmo_o       (tmo)
    );

    function automatic logic [7:0] model_byte(int idx);
        if (idx < m_busy_n || idx == m_glitch) begin
            if (m_mode)
                return {m_fin[7], idx[0], m_fin[5:0]};
            if (m_op)
                return 8'h2A;
            return {~m_exp[7], m_exp[6:0] ^ 7'h15};
        end
        return m_fin;
    endfunction

    // gap monitor and device model, sampled away from the active edge
    always @(negedge clk) begin
        if (busy && !rd_req && k > 0) begin
            run = run + 1;
        end else if (run > 0) begin
            ngaps   = ngaps + 1;
            lastgap = run;
            run     = 0;
        end
        if (rd_req) begin
            rd_valid = 1'b1;
            rd_data  = model_byte(k);
            k        = k + 1;
        end else begin
            rd_valid = 1'b0;
        end
    end

    always @(posedge clk) begin
        cycles = cycles + 1;
        if (cycles > 100000) begin
            errs   = errs + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act=%0d cycles exp<=100000", cycles);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    task automatic check(input logic ok, input string tag, input int act, input int expv);
        checks = checks + 1;
        if (!ok) begin
            errs = errs + 1;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, expv);
        end
    endtask

    // outcome: 0 none, 1 done, 2 err, 3 tmo
    task automatic run_op(input logic md, input logic o, input logic [7:0] e,
                          input int busy_n, input logic [7:0] fin, input int glitch,
                          input logic stray, output int outcome, output int reads);
        int  nstb;
        int  early;
        logic seen;
        @(negedge clk);
        m_mode = md; m_op = o; m_exp = e; m_fin = fin;
        m_busy_n = busy_n; m_glitch = glitch;
        k = 0; ngaps = 0; lastgap = 0; run = 0;
        mode = md; op = o; exp_b = e; start = 1'b1;
        nstb  = o ? ESTB : PSTB;
        early = 0;
        for (int i = 0; i < nstb; i++) begin
            @(negedge clk);
            start = 1'b0;
            wstb  = 1'b1;
            if (rd_req) early = early + 1;
            @(negedge clk);
            wstb = 1'b0;
            if (i < nstb - 1 && rd_req) early = early + 1;
            if (i == nstb - 1)
                check(rd_req, "R2 request after last strobe", int'(rd_req), 1);
            if (stray && i == 1) begin
                @(negedge clk);
                start = 1'b1; mode = ~md; op = ~o; exp_b = ~e;
                if (rd_req) early = early + 1;
                @(negedge clk);
                start = 1'b0; mode = md; op = o; exp_b = e;
                check(busy, "R1 busy held through second start", int'(busy), 1);
            end
        end
        check(early == 0, "R2 no request before last strobe", early, 0);
        seen = 1'b0;
        outcome = 0;
        for (int c = 0; c < 400 && !seen; c++) begin
            @(negedge clk);
            if (done || err || tmo) begin
                seen = 1'b1;
                outcome = done ? 1 : (err ? 2 : 3);
                check(!busy, "R11 flag coincides with busy low", int'(busy), 0);
                check($countones({done, err, tmo}) == 1, "R11 single flag",
                      $countones({done, err, tmo}), 1);
            end
        end
        reads = k;
        @(negedge clk);
        check(!(done || err || tmo), "R11 flag lasts one cycle",
              int'({done, err, tmo}), 0);
    endtask

    task automatic t_reset();
        check(!busy && !rd_req, "R12 busy/req low after reset", int'({busy, rd_req}), 0);
        check(!(done || err || tmo), "R12 flags low after reset", int'({done, err, tmo}), 0);
    endtask

    task automatic t_data_prog();
        int oc, rd;
        run_op(1'b0, 1'b0, 8'hA5, 3, 8'hA5, -1, 1'b0, oc, rd);
        check(oc == 1, "R3 data-poll program done", oc, 1);
        check(rd == 6, "R6 data-poll program read count", rd, 6);
        check(ngaps == 1 && lastgap == SETTLE, "R6 settle gap length", lastgap, SETTLE);
    endtask

    task automatic t_data_erase();
        int oc, rd;
        run_op(1'b0, 1'b1, 8'h00, 2, 8'hFF, -1, 1'b0, oc, rd);
        check(oc == 1, "R4 data-poll erase done", oc, 1);
        check(rd == 5, "R4 data-poll erase read count", rd, 5);
    endtask

    task automatic t_erase_mismatch();
        int oc, rd;
        run_op(1'b0, 1'b1, 8'h00, 0, 8'hFE, -1, 1'b0, oc, rd);
        check(oc == 2, "R9 erase settled with wrong byte", oc, 2);
        check(rd == 2, "R9 reads before failure", rd, 2);
    endtask

    task automatic t_prog_mismatch();
        int oc, rd;
        run_op(1'b0, 1'b0, 8'h96, 1, 8'h97, -1, 1'b0, oc, rd);
        check(oc == 2, "R9 program settled with wrong byte", oc, 2);
        check(rd == 3, "R9 program reads before failure", rd, 3);
    endtask

    task automatic t_toggle_prog();
        int oc, rd;
        run_op(1'b1, 1'b0, 8'h3C, 4, 8'h3C, -1, 1'b0, oc, rd);
        check(oc == 1, "R5 toggle program done", oc, 1);
        check(rd == 8, "R5 toggle program read count", rd, 8);
    endtask

    task automatic t_toggle_erase();
        int oc, rd;
        run_op(1'b1, 1'b1, 8'h00, 3, 8'hFF, -1, 1'b0, oc, rd);
        check(oc == 1, "R5 toggle erase done", oc, 1);
        check(rd == 7, "R5 toggle erase read count", rd, 7);
    endtask

    task automatic t_toggle_first();
        int oc, rd;
        run_op(1'b1, 1'b0, 8'h3C, 0, 8'h3C, -1, 1'b0, oc, rd);
        check(rd == 4, "R5 first toggle read not a completion", rd, 4);
        check(ngaps == 1 && lastgap == SETTLE, "R6 toggle settle gap", lastgap, SETTLE);
    endtask

    task automatic t_glitch();
        int oc, rd;
        run_op(1'b0, 1'b0, 8'h81, 2, 8'h81, 3, 1'b0, oc, rd);
        check(oc == 1, "R8 done after busy confirmation", oc, 1);
        check(rd == 7, "R8 read count with re-poll", rd, 7);
        check(ngaps == 2, "R8 settle repeated", ngaps, 2);
    endtask

    task automatic t_timeout();
        int oc, rd;
        run_op(1'b0, 1'b0, 8'h11, 100, 8'h11, -1, 1'b0, oc, rd);
        check(oc == 3, "R10 timeout flag", oc, 3);
        check(rd == MAXP, "R10 polls before timeout", rd, MAXP);
    endtask

    task automatic t_timeout_edge();
        int oc, rd;
        run_op(1'b0, 1'b0, 8'h42, MAXP - 1, 8'h42, -1, 1'b0, oc, rd);
        check(oc == 1, "R10 completion on last allowed poll", oc, 1);
        check(rd == MAXP + 2, "R10 boundary read count", rd, MAXP + 2);
    endtask

    task automatic t_second_start();
        int oc, rd;
        run_op(1'b0, 1'b0, 8'h5A, 1, 8'h5A, -1, 1'b1, oc, rd);
        check(oc == 1, "R1 second start ignored, original job done", oc, 1);
        check(rd == 4, "R1 original job read count", rd, 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !rd_req && !done, "R12 outputs low in reset",
              int'({busy, rd_req, done}), 0);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_data_prog();
        t_data_erase();
        t_erase_mismatch();
        t_prog_mismatch();
        t_toggle_prog();
        t_toggle_erase();
        t_toggle_first();
        t_glitch();
        t_timeout();
        t_timeout_edge();
        t_second_start();
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule